// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps the coherence state of every line in one private, direct-mapped cache that sits on a shared snooping bus. Each line holds a tag, one data word and one of four states: Modified (sole copy, dirty), Exclusive (sole copy, clean), Shared (clean, other copies may exist) and Invalid. The processor side presents one read or write at a time. Hits that need no bus traffic complete in one cycle. Misses, and writes that need ownership, become a bus request. The request is held until the bus grants it, and the fill data returns in the grant cycle.

On the bus side the controller watches the transactions of other caches. In the same cycle it drives its contribution to the wired-OR shared line. If it holds the only dirty copy it also drives a flush with that data. The line's new state is applied at the next clock edge. A fill started by a read samples the shared line in the grant cycle and installs the line as Exclusive or Shared. This lets a later write to an Exclusive line turn it Modified with no bus transaction.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A read that misses raises `bus_req_valid` with command 2'b00 (read) and the request address. While any bus request is pending, `cpu_req_ready` is low, and a read or read-exclusive request holds its command and address until `bus_gnt`.
- R2: In the grant cycle of a read fill, the line is installed Exclusive if `bus_shared_in` is 0 and Shared if it is 1. The response carries `bus_fill_data` one cycle after the grant.
- R3: A write that misses, or a write to a Shared line, issues command 2'b01 (read-exclusive). The line becomes Modified and holds the write data, and the response returns the write data one cycle after the grant.
- R4: A write to an Exclusive line makes it Modified with no bus request, and the response follows one cycle after acceptance.
- R5: Reads that hit M, E or S, and writes that hit M, raise no bus request. The response follows one cycle after acceptance: the line data for a read, the write data for a write.
- R6: `snp_shared` is high in the cycle of a snoop exactly when the snooped index holds a valid line with a matching tag. An Invalid line or a tag mismatch leaves it low.
- R7: A snoop that hits a Modified line raises `snp_flush` with the line data on `snp_flush_data` in the same cycle. A snooped read (`snp_cmd`=0) leaves the line Shared, and a snooped read-exclusive (`snp_cmd`=1) leaves it Invalid.
- R8: A snooped read-exclusive invalidates any valid matching line. A snooped read turns an Exclusive or Shared line into Shared.
- R9: A miss whose index holds a Modified line with another tag first issues a write-back, command 2'b10, with the old address and data on `bus_req_wdata`, and then issues the fill request. An Exclusive or Shared victim is dropped with no write-back.
- R10: When a snoop and an accepted processor request hit the same line in one cycle, the snoop's state change is applied first, and the request is decided against the resulting state.
- R11: After reset all lines are Invalid, `cpu_req_ready` is high, and neither `bus_req_valid` nor `cpu_resp_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Controller idle, request accepted this cycle |
| cpu_resp_valid | output | 1 | Request completed |
| cpu_resp_rdata | output | DATA_W | Read data, or the written data for a write |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 00 read, 01 read-exclusive, 10 write-back |
| bus_req_addr | output | ADDR_W | Address of the bus transaction |
| bus_req_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Current bus request is granted this cycle |
| bus_fill_data | input | DATA_W | Fill data valid in the grant cycle |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 1 | 0 = read, 1 = read-exclusive |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache's contribution to the shared line |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_flush_data | output | DATA_W | Flushed data |

## Verification
On every cycle the assertions check how the bus handshake is ordered. A pending fill request holds its command and address until granted. A granted write-back is always followed by a fill request, and a granted fill always completes a response. A shared or flush indication only appears during a snoop, and the request port is closed while the bus is in use. Only the bench's scenarios show which state a line actually holds. That covers the choice of Exclusive or Shared from the shared line, the silent Exclusive-to-Modified write, the state each snoop leaves behind, victim write-back versus silent drop, and the ordering when a snoop and a request collide. The bench brings these out through later bus traffic and snoop responses.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_S = 2'b01,
      ST_E = 2'b10,
      ST_M = 2'b11
   } line_st_e;

   typedef enum logic [1:0] {
      BC_RD  = 2'b00,
      BC_RDX = 2'b01,
      BC_WB  = 2'b10
   } bus_cmd_e;

   // State a valid line takes after another cache's transaction is observed.
   function automatic line_st_e snoop_next(line_st_e cur, logic is_rdx);
      if (is_rdx || cur == ST_I) return ST_I;
      return ST_S;
   endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   // snoop update port: state only
   input  logic              snp_we,
   input  logic [IDX_W-1:0]  snp_idx,
   input  line_st_e          snp_state,
   // local update port: wins over the snoop port on the same index
   input  logic              loc_we,
   input  logic [IDX_W-1:0]  loc_idx,
   input  line_st_e          loc_state,
   input  logic [TAG_W-1:0]  loc_tag,
   input  logic [DATA_W-1:0] loc_data,
   // read port A (request side)
   input  logic [IDX_W-1:0]  a_idx,
   output line_st_e          a_state,
   output logic [TAG_W-1:0]  a_tag,
   output logic [DATA_W-1:0] a_data,
   // read port B (snoop side)
   input  logic [IDX_W-1:0]  b_idx,
   output line_st_e          b_state,
   output logic [TAG_W-1:0]  b_tag,
   output logic [DATA_W-1:0] b_data
);
   localparam int LINES = 1 << IDX_W;

   line_st_e          st_q   [LINES];
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LINES; i++) begin
         if (!rst_n) begin
            st_q[i]   <= ST_I;
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end else if (loc_we && loc_idx == IDX_W'(i)) begin
            st_q[i]   <= loc_state;
            tag_q[i]  <= loc_tag;
            data_q[i] <= loc_data;
         end else if (snp_we && snp_idx == IDX_W'(i)) begin
            st_q[i]   <= snp_state;
         end
      end
   end

   assign a_state = st_q[a_idx];
   assign a_tag   = tag_q[a_idx];
   assign a_data  = data_q[a_idx];
   assign b_state = st_q[b_idx];
   assign b_tag   = tag_q[b_idx];
   assign b_data  = data_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
#(
   parameter int TAG_W  = 9,
   parameter int DATA_W = 8
) (
   input  logic              snp_valid,
   input  logic              snp_is_rdx,
   input  logic [TAG_W-1:0]  snp_tag,
   input  line_st_e          line_state,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [DATA_W-1:0] line_data,
   output logic              hit,
   output logic              shared,
   output logic              flush,
   output logic [DATA_W-1:0] flush_data,
   output line_st_e          next_state
);
   assign hit        = snp_valid && (line_state != ST_I) && (line_tag == snp_tag);
   assign shared     = hit;
   assign flush      = hit && (line_state == ST_M);
   assign flush_data = flush ? line_data : '0;
   assign next_state = snoop_next(line_state, snp_is_rdx);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_req_ready,
   output logic              cpu_resp_valid,
   output logic [DATA_W-1:0] cpu_resp_rdata,
   output logic              bus_req_valid,
   output logic [1:0]        bus_req_cmd,
   output logic [ADDR_W-1:0] bus_req_addr,
   output logic [DATA_W-1:0] bus_req_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_fill_data,
   input  logic              bus_shared_in,
   input  logic              snp_valid,
   input  logic              snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_flush_data
);
   localparam int TAG_W = ADDR_W - IDX_W;

   generate
      if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
         $error("IDX_W must lie between 1 and ADDR_W-1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   typedef enum logic [1:0] {F_IDLE, F_WB, F_BUS} fsm_e;

   fsm_e              fsm_q;
   logic              pend_wr_q;
   logic [IDX_W-1:0]  pend_idx_q;
   logic [TAG_W-1:0]  pend_tag_q;
   logic [DATA_W-1:0] pend_wd_q;

   logic [IDX_W-1:0]  req_idx, snp_idx, sel_idx;
   logic [TAG_W-1:0]  req_tag, snp_tag, cmp_tag;
   line_st_e          a_st, b_st, snp_nxt, eff_st, loc_st;
   logic [TAG_W-1:0]  a_tag, b_tag, loc_tag;
   logic [DATA_W-1:0] a_data, b_data, loc_data;
   logic              loc_we, snp_upd;
   logic              line_hit, need_bus, accept, vict_m;
   bus_cmd_e          cmd;

   assign req_idx = cpu_req_addr[IDX_W-1:0];
   assign req_tag = cpu_req_addr[ADDR_W-1:IDX_W];
   assign snp_idx = snp_addr[IDX_W-1:0];
   assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
   assign sel_idx = (fsm_q == F_IDLE) ? req_idx : pend_idx_q;
   assign cmp_tag = (fsm_q == F_IDLE) ? req_tag : pend_tag_q;

   mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .snp_we   (snp_upd),
      .snp_idx  (snp_idx),
      .snp_state(snp_nxt),
      .loc_we   (loc_we),
      .loc_idx  (sel_idx),
      .loc_state(loc_st),
      .loc_tag  (loc_tag),
      .loc_data (loc_data),
      .a_idx    (sel_idx),
      .a_state  (a_st),
      .a_tag    (a_tag),
      .a_data   (a_data),
      .b_idx    (snp_idx),
      .b_state  (b_st),
      .b_tag    (b_tag),
      .b_data   (b_data)
   );

   mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .snp_valid (snp_valid),
      .snp_is_rdx(snp_cmd),
      .snp_tag   (snp_tag),
      .line_state(b_st),
      .line_tag  (b_tag),
      .line_data (b_data),
      .hit       (snp_upd),
      .shared    (snp_shared),
      .flush     (snp_flush),
      .flush_data(snp_flush_data),
      .next_state(snp_nxt)
   );

   // The request is judged against the state the snoop leaves behind.
   assign eff_st   = (snp_upd && snp_idx == sel_idx) ? snp_nxt : a_st;
   assign line_hit = (eff_st != ST_I) && (a_tag == cmp_tag);
   assign need_bus = !line_hit || (cpu_req_write && eff_st == ST_S);
   assign accept   = (fsm_q == F_IDLE) && cpu_req_valid;
   assign vict_m   = (eff_st == ST_M);

   always_comb begin
      loc_we   = 1'b0;
      loc_st   = ST_I;
      loc_tag  = a_tag;
      loc_data = a_data;
      unique case (fsm_q)
         F_IDLE: begin
            if (accept && !need_bus && cpu_req_write) begin
               loc_we   = 1'b1;
               loc_st   = ST_M;
               loc_tag  = req_tag;
               loc_data = cpu_req_wdata;
            end
         end
         F_WB: begin
            if (vict_m && bus_gnt) begin
               loc_we = 1'b1;
               loc_st = ST_I;
            end
         end
         F_BUS: begin
            if (bus_gnt) begin
               loc_we   = 1'b1;
               loc_tag  = pend_tag_q;
               loc_st   = pend_wr_q ? ST_M : (bus_shared_in ? ST_S : ST_E);
               loc_data = pend_wr_q ? pend_wd_q : bus_fill_data;
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      bus_req_valid = 1'b0;
      cmd           = BC_RD;
      bus_req_addr  = {pend_tag_q, pend_idx_q};
      bus_req_wdata = '0;
      unique case (fsm_q)
         F_WB: begin
            bus_req_valid = vict_m;
            cmd           = BC_WB;
            bus_req_addr  = {a_tag, pend_idx_q};
            bus_req_wdata = a_data;
         end
         F_BUS: begin
            bus_req_valid = 1'b1;
            cmd           = pend_wr_q ? BC_RDX : BC_RD;
         end
         default: ;
      endcase
   end

   assign bus_req_cmd   = cmd;
   assign cpu_req_ready = (fsm_q == F_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q          <= F_IDLE;
         cpu_resp_valid <= 1'b0;
         cpu_resp_rdata <= '0;
         pend_wr_q      <= 1'b0;
         pend_idx_q     <= '0;
         pend_tag_q     <= '0;
         pend_wd_q      <= '0;
      end else begin
         cpu_resp_valid <= 1'b0;
         unique case (fsm_q)
            F_IDLE: begin
               if (accept) begin
                  if (!need_bus) begin
                     cpu_resp_valid <= 1'b1;
                     cpu_resp_rdata <= cpu_req_write ? cpu_req_wdata : a_data;
                  end else begin
                     pend_wr_q  <= cpu_req_write;
                     pend_idx_q <= req_idx;
                     pend_tag_q <= req_tag;
                     pend_wd_q  <= cpu_req_wdata;
                     fsm_q      <= (!line_hit && vict_m) ? F_WB : F_BUS;
                  end
               end
            end
            F_WB: begin
               if (!vict_m || bus_gnt) fsm_q <= F_BUS;
            end
            F_BUS: begin
               if (bus_gnt) begin
                  cpu_resp_valid <= 1'b1;
                  cpu_resp_rdata <= pend_wr_q ? pend_wd_q : bus_fill_data;
                  fsm_q          <= F_IDLE;
               end
            end
            default: fsm_q <= F_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_req_ready,
   input logic       cpu_resp_valid,
   input logic       bus_req_valid,
   input logic [1:0] bus_req_cmd,
   input logic [11:0] bus_req_addr,
   input logic       bus_gnt,
   input logic       snp_valid,
   input logic       snp_shared,
   input logic       snp_flush
);
   // R1
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && !bus_gnt && bus_req_cmd != 2'b10
      |=> bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_cmd));

   // R1
   cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> bus_req_cmd != 2'b11);

   // R1
   busy_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> !cpu_req_ready);

   // R9
   wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && bus_gnt && bus_req_cmd == 2'b10
      |=> bus_req_valid && bus_req_cmd != 2'b10);

   // R3
   fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && bus_gnt && bus_req_cmd != 2'b10
      |=> cpu_resp_valid && cpu_req_ready);

   // R6
   shared_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> snp_valid);

   // R7
   flush_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> snp_shared);

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req_ready (cpu_req_ready),
   .cpu_resp_valid(cpu_resp_valid),
   .bus_req_valid (bus_req_valid),
   .bus_req_cmd   (bus_req_cmd),
   .bus_req_addr  (bus_req_addr[11:0]),
   .bus_gnt       (bus_gnt),
   .snp_valid     (snp_valid),
   .snp_shared    (snp_shared),
   .snp_flush     (snp_flush)
);

// File: tb/mesi_snoop_ctrl_bench.sv
module mesi_snoop_ctrl_bench;
   localparam int AW = 12;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic [DW-1:0] cpu_req_wdata = '0;
   logic          cpu_req_ready, cpu_resp_valid;
   logic [DW-1:0] cpu_resp_rdata;
   logic          bus_req_valid;
   logic [1:0]    bus_req_cmd;
   logic [AW-1:0] bus_req_addr;
   logic [DW-1:0] bus_req_wdata;
   logic          bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic [DW-1:0] bus_fill_data = '0;
   logic          snp_valid = 1'b0, snp_cmd = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_shared, snp_flush;
   logic [DW-1:0] snp_flush_data;

   int vectors = 0;
   int miscompares = 0;
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   localparam logic [AW-1:0] A = 12'h010, B = 12'h011, C = 12'h018, D = 12'h025;

   always #10 clk = ~clk;

   mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(3), .DATA_W(DW)) u_mesi_snoop_ctrl (.*);

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every response
   always @(negedge clk) begin
      if (rst_n && cpu_resp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected response", cpu_resp_rdata, 0);
         end else begin
            automatic logic [DW-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(cpu_resp_rdata == e, t, "response data", cpu_resp_rdata, e);
         end
      end
   end

   task automatic cpu_issue(input bit w, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic [DW-1:0] exp,
                            input string tag);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      cpu_req_valid = 1'b0;
   endtask

   task automatic expect_no_bus(input string tag);
      check(bus_req_valid == 1'b0, tag, "bus request on hit", bus_req_valid, 0);
   endtask

   task automatic serve(input logic [1:0] c, input logic [AW-1:0] a,
                        input logic [DW-1:0] fill, input bit sh, input string tag);
      check(bus_req_valid == 1'b1, tag, "bus request valid", bus_req_valid, 1);
      check(bus_req_cmd == c, tag, "bus command", bus_req_cmd, c);
      check(bus_req_addr == a, tag, "bus address", bus_req_addr, a);
      check(cpu_req_ready == 1'b0, tag, "ready while busy", cpu_req_ready, 0);
      bus_gnt = 1'b1; bus_fill_data = fill; bus_shared_in = sh;
      @(negedge clk);
      bus_gnt = 1'b0; bus_shared_in = 1'b0;
   endtask

   task automatic serve_wb(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input string tag);
      check(bus_req_valid == 1'b1 && bus_req_cmd == 2'b10, tag, "write-back cmd",
            bus_req_cmd, 2);
      check(bus_req_addr == a, tag, "write-back address", bus_req_addr, a);
      check(bus_req_wdata == d, tag, "write-back data", bus_req_wdata, d);
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
   endtask

   task automatic snoop(input bit rdx, input logic [AW-1:0] a, input bit exp_sh,
                        input bit exp_fl, input logic [DW-1:0] exp_d, input string tag);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = rdx; snp_addr = a;
      #2;
      check(snp_shared == exp_sh, tag, "snoop shared", snp_shared, exp_sh);
      check(snp_flush == exp_fl, tag, "snoop flush", snp_flush, exp_fl);
      if (exp_fl) check(snp_flush_data == exp_d, tag, "flush data", snp_flush_data, exp_d);
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R11", "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(cpu_req_ready == 1'b1, "R11", "ready after reset", cpu_req_ready, 1);
      check(bus_req_valid == 1'b0, "R11", "no bus request", bus_req_valid, 0);
      check(cpu_resp_valid == 1'b0, "R11", "no response", cpu_resp_valid, 0);
      snoop(1'b0, A, 1'b0, 1'b0, 0, "R11");

      // R1 / R2: read miss, no sharer -> E
      cpu_issue(1'b0, A, 0, 8'h5A, "R2");
      serve(2'b00, A, 8'h5A, 1'b0, "R1");
      // R5: read hit
      cpu_issue(1'b0, A, 0, 8'h5A, "R5");
      expect_no_bus("R5");
      // R4: silent E -> M
      cpu_issue(1'b1, A, 8'h11, 8'h11, "R4");
      expect_no_bus("R4");
      // R7: snooped read on M flushes, goes S
      snoop(1'b0, A, 1'b1, 1'b1, 8'h11, "R7");
      snoop(1'b0, A, 1'b1, 1'b0, 0, "R7");
      // R3: write to S issues read-exclusive
      cpu_issue(1'b1, A, 8'h22, 8'h22, "R3");
      serve(2'b01, A, 8'h11, 1'b0, "R3");
      // R7: read-exclusive snoop on M flushes and invalidates
      snoop(1'b1, A, 1'b1, 1'b1, 8'h22, "R7");
      snoop(1'b0, A, 1'b0, 1'b0, 0, "R8");

      // R2: read fill with sharer -> S, then write must go to the bus
      cpu_issue(1'b0, B, 0, 8'h33, "R2");
      serve(2'b00, B, 8'h33, 1'b1, "R2");
      cpu_issue(1'b1, B, 8'h44, 8'h44, "R2");
      serve(2'b01, B, 8'h33, 1'b0, "R2");
      // R8: read-exclusive snoop on a valid line invalidates it
      snoop(1'b1, B, 1'b1, 1'b1, 8'h44, "R8");
      snoop(1'b1, B, 1'b0, 1'b0, 0, "R8");

      // R9: fill C at index 0 (A invalid, no write-back), make it M
      cpu_issue(1'b0, C, 0, 8'h66, "R9");
      serve(2'b00, C, 8'h66, 1'b0, "R9");
      cpu_issue(1'b1, C, 8'h77, 8'h77, "R4");
      expect_no_bus("R4");
      // R9: read A evicts dirty C with a write-back first
      cpu_issue(1'b0, A, 0, 8'h88, "R9");
      serve_wb(C, 8'h77, "R9");
      serve(2'b00, A, 8'h88, 1'b0, "R9");
      // R9: A is E, evicted silently
      cpu_issue(1'b0, C, 0, 8'h99, "R9");
      serve(2'b00, C, 8'h99, 1'b1, "R9");
      // R6: tag mismatch at same index
      snoop(1'b0, A, 1'b0, 1'b0, 0, "R6");

      // R10: snooped read-exclusive and local read of an S line in one cycle
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = 1'b1; snp_addr = C;
      cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = C;
      exp_q.push_back(8'hAB); tag_q.push_back("R10");
      #2;
      check(snp_shared == 1'b1, "R10", "snoop shared", snp_shared, 1);
      @(negedge clk);
      snp_valid = 1'b0; cpu_req_valid = 1'b0;
      serve(2'b00, C, 8'hAB, 1'b0, "R10");
      // R10: snooped read and local write of an E line in one cycle
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = 1'b0; snp_addr = C;
      cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = C; cpu_req_wdata = 8'hCD;
      exp_q.push_back(8'hCD); tag_q.push_back("R10");
      #2;
      check(snp_shared == 1'b1 && snp_flush == 1'b0, "R10", "snoop on E",
            {snp_shared, snp_flush}, 2);
      @(negedge clk);
      snp_valid = 1'b0; cpu_req_valid = 1'b0;
      serve(2'b01, C, 8'hAB, 1'b0, "R10");
      snoop(1'b0, C, 1'b1, 1'b1, 8'hCD, "R10");

      // R3 / R5: write miss, then write and read hits on M
      cpu_issue(1'b1, D, 8'hE1, 8'hE1, "R3");
      serve(2'b01, D, 8'h00, 1'b1, "R3");
      cpu_issue(1'b1, D, 8'hE2, 8'hE2, "R5");
      expect_no_bus("R5");
      cpu_issue(1'b0, D, 0, 8'hE2, "R5");
      expect_no_bus("R5");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R5", "responses outstanding", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule